// File: doc/BRIEF.md
# Segmented Oscillator Control Encoder

This block turns the binary control word from a node's loop filter into the enable pattern for a bank of parallel tuning cells hung on a ring oscillator. Each enabled cell slows or speeds the ring by about one step, so the count of enabled cells sets the frequency. That count must never fall when the code rises, even with mismatch between cells.

The two lowest code bits drive binary-weighted groups of one cell and two cells. The remaining upper bits drive equal segments of four cells through a thermometer decoder. One base cell is always on. The enabled count is therefore the code plus one, up to the bank's limit. Any upper code past the last segment saturates with every usable cell enabled. Any cells left over from the segment division are never driven.

The pattern is held in a register. That register is the end of the node's critical timing path, and it feeds the cell bank directly. It loads a new pattern on every cycle that `code_valid` is high. While `rst_n` is low it loads the pattern for the programmable centre code instead. The block cannot stall, so it has no ready output and applies no back-pressure.

Top module: `soe_encoder`

## Requirements
- R1: Cell 0 (the base cell) is enabled in every pattern the register holds.
- R2: For a code c, the number of enabled cells is min(c + 1, 264) with the default 266-cell bank and 10-bit code.
- R3: The upper code u = c >> 2 drives 65 segments of four cells each. Segment k occupies cells 4+4k to 7+4k, and all four of its cells are enabled exactly when k < u.
- R4: When not saturated, cell 1 follows code bit 0, and cells 2 and 3 both follow code bit 1.
- R5: When u > 65 (codes 264 to 1023), all cells 0 to 263 are enabled.
- R6: The output changes only one clock edge after a cycle with code_valid high. A cycle with code_valid low leaves the output unchanged whatever code_in is.
- R7: At every clock edge with rst_n low, the register loads the pattern for center_code, and code_valid and code_in are ignored.
- R8: Spare cells 264 and 265 are never enabled.
- R9: Loading a code that is not lower than the code currently held never reduces the enabled count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the centre pattern |
| center_code | input | 10 | Code whose pattern the register loads during reset |
| code_valid | input | 1 | Loads code_in at this edge when high |
| code_in | input | 10 | Control word from the loop filter |
| en_out | output | 266 | Registered enable pattern, one bit per tuning cell |

## Verification
The assertions check on every cycle that:
- the thermometer vector has no gaps;
- out-of-range codes saturate;
- the base cell stays on and the spare cells stay off;
- the output holds when no code is offered;
- the enabled count matches the held code and never drops when a higher code loads.

Only the bench scenarios can show the exact cell positions of every pattern across a full sweep of all 1024 codes. They also show that reset loads whichever centre code is presented, and that random streams with gaps in `code_valid` produce the expected pattern after each edge.

// File: rtl/soe_pkg.sv
package soe_pkg;
  // binary-weighted low bits; group j holds 2**j cells
  localparam int unsigned BIN_BITS  = 2;
  localparam int unsigned BIN_CELLS = (1 << BIN_BITS) - 1;
  // one thermometer segment equals one step of the upper code
  localparam int unsigned SEG_UNITS = 1 << BIN_BITS;

  function automatic int unsigned seg_count(input int unsigned n_elem);
    return (n_elem - 1 - BIN_CELLS) / SEG_UNITS;
  endfunction
endpackage

// File: rtl/soe_split.sv
module soe_split #(
  parameter int unsigned CODE_W   = 10,
  parameter int unsigned BIN_BITS = 2,
  parameter int unsigned N_SEG    = 65,
  localparam int unsigned SEG_W   = CODE_W - BIN_BITS
) (
  input  logic [CODE_W-1:0]   code,
  output logic [BIN_BITS-1:0] bin,
  output logic [SEG_W-1:0]    seg_cnt
);
  logic [SEG_W-1:0] upper;
  logic             over;

  assign upper = code[CODE_W-1:BIN_BITS];
  assign over  = (upper > SEG_W'(N_SEG));

  always_comb begin
    if (over) begin
      seg_cnt = SEG_W'(N_SEG);
      bin     = '1;
    end else begin
      seg_cnt = upper;
      bin     = code[BIN_BITS-1:0];
    end
  end

  // saturation of out-of-range upper codes
  always_comb begin
    if (!$isunknown(code) && (code[CODE_W-1:BIN_BITS] > SEG_W'(N_SEG)))
      assert_saturate_R5: assert (seg_cnt == SEG_W'(N_SEG) && bin == '1)
        else $error("saturation not applied");
  end
endmodule

// File: rtl/soe_therm.sv
module soe_therm #(
  parameter int unsigned SEG_W = 8,
  parameter int unsigned N_SEG = 65
) (
  input  logic [SEG_W-1:0] seg_cnt,
  output logic [N_SEG-1:0] therm
);
  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    assign therm[k] = (seg_cnt > SEG_W'(k));
  end

  // a valid thermometer word is all ones from bit 0 upward, no gaps
  always_comb begin
    if (!$isunknown(therm))
      assert_thermo_R3: assert (((therm + 1'b1) & therm) == '0)
        else $error("thermometer gap");
  end
endmodule

// File: rtl/soe_encoder.sv
module soe_encoder
  import soe_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned N_ELEM = 266
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] center_code,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  output logic [N_ELEM-1:0] en_out
);
  localparam int unsigned SEG_W  = CODE_W - BIN_BITS;
  localparam int unsigned N_SEG  = seg_count(N_ELEM);
  localparam int unsigned SEG0   = 1 + BIN_CELLS;
  localparam int unsigned MAX_EN = SEG0 + N_SEG * SEG_UNITS;
  localparam int unsigned SPARE  = N_ELEM - MAX_EN;

  logic [CODE_W-1:0]   sel_code;
  logic                load;
  logic [BIN_BITS-1:0] bin;
  logic [SEG_W-1:0]    seg_cnt;
  logic [N_SEG-1:0]    therm;
  logic [N_ELEM-1:0]   pat;
  logic [N_ELEM-1:0]   en_q;
  logic [CODE_W-1:0]   code_q;

  // reset reuses the decode path with the centre code
  assign sel_code = rst_n ? code_in : center_code;
  assign load     = !rst_n || code_valid;

  soe_split #(.CODE_W(CODE_W), .BIN_BITS(BIN_BITS), .N_SEG(N_SEG)) u_split (
    .code(sel_code), .bin(bin), .seg_cnt(seg_cnt)
  );

  soe_therm #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_therm (
    .seg_cnt(seg_cnt), .therm(therm)
  );

  assign pat[0] = 1'b1;
  for (genvar j = 0; j < BIN_BITS; j++) begin : g_bin
    assign pat[(1 << j) +: (1 << j)] = {(1 << j){bin[j]}};
  end
  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    assign pat[SEG0 + k * SEG_UNITS +: SEG_UNITS] = {SEG_UNITS{therm[k]}};
  end
  if (SPARE > 0) begin : g_spare
    assign pat[N_ELEM-1:MAX_EN] = '0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      en_q   <= pat;
      code_q <= sel_code;
    end
  end

  assign en_out = en_q;

  assert_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[0] == 1'b1) else $error("base cell off");

  if (SPARE > 0) begin : g_spare_chk
    assert_spare_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[N_ELEM-1:MAX_EN] == '0) else $error("spare cell on");
  end

  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(en_q) == ((32'(code_q) + 1 > MAX_EN) ? MAX_EN : 32'(code_q) + 1)))
    else $error("count mismatch");

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |=> $stable(en_q)) else $error("output moved without valid");

  assert_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && code_in >= code_q) |=> ($countones(en_q) >= $countones($past(en_q))))
    else $error("count fell");
endmodule

// File: tb/sim_soe_encoder.sv
module sim_soe_encoder;
  localparam int CW = 10;
  localparam int N  = 266;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] center_code = '0;
  logic          code_valid = 1'b0;
  logic [CW-1:0] code_in = '0;
  logic [N-1:0]  en_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  soe_encoder u0 (
    .clk(clk), .rst_n(rst_n), .center_code(center_code),
    .code_valid(code_valid), .code_in(code_in), .en_out(en_out)
  );

  function automatic logic [N-1:0] expect_pat(input int c);
    logic [N-1:0] v = '0;
    int u = c / 4;
    int b = c % 4;
    if (u > 65) begin u = 65; b = 3; end
    v[0] = 1'b1;
    v[1] = b[0];
    v[2] = b[1];
    v[3] = b[1];
    for (int k = 0; k < u; k++) v[4 + 4*k +: 4] = 4'hF;
    return v;
  endfunction

  task automatic chk_pat(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int c, input bit v);
    @(negedge clk);
    code_in = CW'(c);
    code_valid = v;
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    int prev;
    void'($urandom(32'd1234));
    // R7: reset loads the centre code pattern
    center_code = 10'd517;
    code_valid = 1'b1;
    code_in = 10'd3;
    repeat (3) @(negedge clk);
    chk_pat("R7 reset centre 517", en_out, expect_pat(517));
    center_code = 10'd130;
    @(negedge clk);
    chk_pat("R7 reset centre 130", en_out, expect_pat(130));
    code_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pat("R6 idle after reset", en_out, expect_pat(130));

    // sweep every code: R2 count, R3/R4 positions, R9 monotonic, R5 saturation
    prev = 0;
    for (int c = 0; c < 1024; c++) begin
      apply(c, 1'b1);
      chk_pat("R3 R4 sweep pattern", en_out, expect_pat(c));
      chk_int("R2 count", $countones(en_out), (c + 1 > 264) ? 264 : c + 1);
      if ($countones(en_out) < prev) chk_int("R9 monotone", $countones(en_out), prev);
      prev = $countones(en_out);
      if (c >= 264 && c % 97 == 0) chk_int("R5 saturated", $countones(en_out[263:0]), 264);
    end
    chk_int("R1 base cell", int'(en_out[0]), 1);
    chk_int("R8 spare cells", int'(en_out[265:264]), 0);

    // R4 directed binary corners
    apply(2, 1'b1);
    chk_int("R4 code 2 low cells", int'(en_out[3:0]), 4'b1101);
    apply(5, 1'b1);
    chk_int("R4 code 5 low cells", int'(en_out[7:0]), 8'b1111_0011);
    apply(263, 1'b1);
    chk_int("R2 top in-range", $countones(en_out), 264);
    apply(264, 1'b1);
    chk_pat("R5 first saturated", en_out, expect_pat(263));

    // R6 hold with valid low
    apply(40, 1'b1);
    apply(900, 1'b0);
    chk_pat("R6 hold", en_out, expect_pat(40));

    // random stream with gaps in valid
    held = 40;
    for (int i = 0; i < 400; i++) begin
      int c = int'($urandom % 1024);
      bit v = ($urandom % 3) != 0;
      apply(c, v);
      if (v) held = c;
      chk_pat("R6 random stream", en_out, expect_pat(held));
      chk_int("R8 random spare", int'(en_out[265:264]), 0);
    end

    // R7 reset mid-stream ignores code_valid
    @(negedge clk);
    center_code = 10'd1000;
    code_in = 10'd7;
    code_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk_pat("R7 reset saturated centre", en_out, expect_pat(1000));
    code_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule